// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block sequences one successive-approximation converter that is shared by several multiplexed analogue inputs. A reference clock is divided down to a converter clock by a programmable power-of-two divider. A code of zero stops that clock to save power. While the scan runs, the block steps through the enabled channels in ascending order. It drives the multiplexer select and runs a ten-step binary search on each channel, using an external comparator that reports whether the present trial code is above the input. The converter has no sample-and-hold, so the comparator sees the live input on every trial.

Each finished conversion overwrites that channel's result register. The block also raises a one-cycle strobe that carries the channel number, for threshold logic further down the chain. Clearing the run bit stops the scan so that the results can be read while they are stable. A read port returns the result of one selected channel as two bytes. Channel 0 is the master of the scan: while it is disabled, nothing is converted.

Top module: `adc_scan_seq`

## Requirements
- R1: The divider code `div_code_i` sets the converter clock. Code 0 stops it, so no conversion makes progress. Code k from 1 to 7 gives one converter clock every 2^(k-1) reference cycles.
- R2: Each channel conversion takes exactly 12 converter clocks: one setup clock, 10 bit trials and one store clock. With the scan running, consecutive result strobes are therefore 12·2^(k-1) reference cycles apart.
- R3: Channels are converted in ascending index order over the enabled set, and the scan wraps back to channel 0. After a restart, the first conversion is on channel 0. `mux_sel_o` holds the channel under conversion and changes only when a conversion completes or the scan stops.
- R4: While `run_i` is 0, no conversion completes and every result register holds its value.
- R5: While `ch_en_i[0]` is 0, no channel is converted, whatever the other enable bits are.
- R6: The search runs MSB first. A bit under test is cleared when `cmp_hi_i` is 1, which means the trial code is above the input. For an input code V that stays constant, the stored result equals V.
- R7: A result register changes only when a conversion of its own channel completes. Until then, it keeps the previous result.
- R8: The read port returns result bits 9..2 in `rd_msb_o`. `rd_lsb_o` carries result bits 1..0 in bits 1..0, and its bits 7..2 are zero.
- R9: `valid_o` is high for exactly one cycle per completed conversion. In that cycle `valid_ch_o` holds the channel, and the new result is already visible on `result_o`.
- R10: After reset, all results, `trial_o`, `mux_sel_o`, `valid_o`, `valid_ch_o` and both read bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 runs the scan continuously, 0 stops it and freezes the results |
| ch_en_i | input | 4 | Per-channel conversion enables; bit 0 is required for any conversion |
| div_code_i | input | 3 | Converter clock divider code; 0 stops the converter clock |
| cmp_hi_i | input | 1 | Comparator result: 1 when the trial code is above the selected input |
| rd_ch_i | input | 2 | Channel whose result is presented on the read bytes |
| trial_o | output | 10 | Trial code for the comparison DAC |
| mux_sel_o | output | 2 | Analogue multiplexer select |
| result_o | output | 40 | Four 10-bit results; channel n occupies bits 10n+9..10n |
| valid_o | output | 1 | One-cycle strobe for a completed conversion |
| valid_ch_o | output | 2 | Channel of the completed conversion |
| rd_msb_o | output | 8 | Result bits 9..2 of the selected channel |
| rd_lsb_o | output | 8 | Result bits 1..0 of the selected channel, zero-extended |

## Verification
The assertions assume that `cmp_hi_i` is a combinational function of `trial_o` and the input selected by `mux_sel_o`, and that the divider code changes only while the scan is stopped. The trial check and the result-timing checks rely on both. The stimulus keeps within these limits: each input is held constant while the scan runs, and the divider code and enables are changed only with `run_i` low. New input values, enable sets and divider codes are therefore applied between runs, never in the middle of a conversion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned DEF_N_CH  = 4;
  localparam int unsigned DEF_RES_W = 10;
  localparam int unsigned DEF_DIV_W = 3;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_TRIAL = 2'd1,
    PH_STORE = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CNT_W = (1 << DIV_W) - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_code_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             on;

  assign on     = (div_code_i != '0);
  assign lim    = (CNT_W'(1) << (div_code_i - DIV_W'(1))) - CNT_W'(1);
  assign tick_o = on && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!on)    cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_scan_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  localparam int unsigned BIT_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             cmp_hi_i,
  output logic [RES_W-1:0] trial_o,
  output logic             store_o
);
  sar_phase_e       phase_q;
  logic [BIT_W-1:0] bit_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] trial_nxt;

  always_comb begin
    trial_nxt = trial_q;
    if (cmp_hi_i) trial_nxt[bit_q] = 1'b0;
    if (bit_q != '0) trial_nxt[bit_q - BIT_W'(1)] = 1'b1;
  end

  assign store_o = tick_i && !clr_i && (phase_q == PH_STORE);
  assign trial_o = trial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SETUP;
      bit_q   <= '0;
      trial_q <= '0;
    end else if (clr_i) begin
      phase_q <= PH_SETUP;
      bit_q   <= '0;
      trial_q <= '0;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_SETUP: begin
          trial_q <= RES_W'(1) << (RES_W - 1);
          bit_q   <= BIT_W'(RES_W - 1);
          phase_q <= PH_TRIAL;
        end
        PH_TRIAL: begin
          trial_q <= trial_nxt;
          if (bit_q == '0) phase_q <= PH_STORE;
          else             bit_q   <= bit_q - BIT_W'(1);
        end
        default: phase_q <= PH_SETUP;
      endcase
    end
  end
endmodule

// File: rtl/adc_ch_sched.sv
module adc_ch_sched #(
  parameter int unsigned N_CH = 4,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [N_CH-1:0] en_i,
  output logic [CH_W-1:0] ch_o
);
  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] ch_nxt;

  // ascending search above current channel, falling back to master channel 0
  always_comb begin
    ch_nxt = '0;
    for (int k = N_CH - 1; k >= 1; k--) begin
      if ((int'(ch_q) + k) < N_CH && en_i[int'(ch_q) + k])
        ch_nxt = CH_W'(int'(ch_q) + k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ch_q <= '0;
    else if (clr_i) ch_q <= '0;
    else if (adv_i) ch_q <= ch_nxt;
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(N_CH),
  localparam int unsigned LO_W = RES_W - 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [CH_W-1:0]            wr_ch_i,
  input  logic [RES_W-1:0]           wr_data_i,
  input  logic [CH_W-1:0]            rd_ch_i,
  output logic [N_CH-1:0][RES_W-1:0] result_o,
  output logic [7:0]                 rd_msb_o,
  output logic [7:0]                 rd_lsb_o
);
  logic [RES_W-1:0] sel;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           result_o[g] <= '0;
      else if (wr_i && wr_ch_i == CH_W'(g)) result_o[g] <= wr_data_i;
    end
  end

  assign sel      = result_o[rd_ch_i];
  assign rd_msb_o = sel[RES_W-1 -: 8];
  assign rd_lsb_o = {{(8 - LO_W){1'b0}}, sel[LO_W-1:0]};
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned N_CH  = DEF_N_CH,
  parameter int unsigned RES_W = DEF_RES_W,
  parameter int unsigned DIV_W = DEF_DIV_W,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic [N_CH-1:0]            ch_en_i,
  input  logic [DIV_W-1:0]           div_code_i,
  input  logic                       cmp_hi_i,
  input  logic [CH_W-1:0]            rd_ch_i,
  output logic [RES_W-1:0]           trial_o,
  output logic [CH_W-1:0]            mux_sel_o,
  output logic [N_CH-1:0][RES_W-1:0] result_o,
  output logic                       valid_o,
  output logic [CH_W-1:0]            valid_ch_o,
  output logic [7:0]                 rd_msb_o,
  output logic [7:0]                 rd_lsb_o
);
  logic tick;
  logic clr;
  logic store;

  assign clr = !run_i || !ch_en_i[0];

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .div_code_i, .tick_o(tick)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .cmp_hi_i,
    .trial_o, .store_o(store)
  );

  adc_ch_sched #(.N_CH(N_CH)) u_sched (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(store), .en_i(ch_en_i), .ch_o(mux_sel_o)
  );

  adc_result_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni, .wr_i(store), .wr_ch_i(mux_sel_o), .wr_data_i(trial_o),
    .rd_ch_i, .result_o, .rd_msb_o, .rd_lsb_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      valid_ch_o <= '0;
    end else begin
      valid_o <= store;
      if (store) valid_ch_o <= mux_sel_o;
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned RES_W = 10,
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       run_i,
  input logic [N_CH-1:0]            ch_en_i,
  input logic [DIV_W-1:0]           div_code_i,
  input logic [RES_W-1:0]           trial_o,
  input logic [CH_W-1:0]            mux_sel_o,
  input logic [N_CH-1:0][RES_W-1:0] result_o,
  input logic                       valid_o,
  input logic [CH_W-1:0]            valid_ch_o
);
  assert_done_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(run_i && ch_en_i[0] && div_code_i != '0));

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_mux_moves_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != $past(mux_sel_o)) |-> (valid_o || mux_sel_o == '0));

  assert_result_moves_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != $past(result_o)) |-> valid_o);

  assert_result_from_trial_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o[valid_ch_o] == $past(trial_o)));

  assert_master_gates_scan_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_en_i[0] && $past(!ch_en_i[0])) |-> !valid_o);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH), .RES_W(RES_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [3:0] en = 4'b0000;
  logic [2:0] div = 3'd0;
  logic       cmp_hi;
  logic [1:0] rd_ch = 2'd0;
  logic [9:0] trial;
  logic [1:0] mux_sel;
  logic [3:0][9:0] result;
  logic       valid;
  logic [1:0] valid_ch;
  logic [7:0] rd_msb, rd_lsb;

  logic [9:0] vin [4];
  logic [9:0] exp_res [4];
  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  bit mon_on = 0, have_last = 0, prev_valid = 0, finished = 0;
  int last_cyc = 0, period = 0;
  logic [1:0] exp_ch = 2'd0;

  always #10 clk = ~clk;

  assign cmp_hi = trial > vin[mux_sel];

  adc_scan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .ch_en_i(en), .div_code_i(div),
    .cmp_hi_i(cmp_hi), .rd_ch_i(rd_ch), .trial_o(trial), .mux_sel_o(mux_sel),
    .result_o(result), .valid_o(valid), .valid_ch_o(valid_ch),
    .rd_msb_o(rd_msb), .rd_lsb_o(rd_lsb)
  );

  function automatic logic [1:0] next_ch(input logic [1:0] c, input logic [3:0] e);
    for (int k = int'(c) + 1; k < 4; k++) if (e[k]) return 2'(k);
    return 2'd0;
  endfunction

  function automatic int slot_cycles(input logic [2:0] d);
    return 12 * (1 << (int'(d) - 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (valid) pulses++;
      if (valid && prev_valid) chk("R9 strobe width", 1, 0);
      if (mon_on && valid) begin
        chk("R3 scan order", int'(valid_ch), int'(exp_ch));
        chk("R6 SAR result", int'(result[valid_ch]), int'(vin[valid_ch]));
        exp_res[valid_ch] = vin[valid_ch];
        if (have_last) chk("R2 slot spacing", cyc - last_cyc, period);
        have_last = 1;
        last_cyc  = cyc;
        exp_ch    = next_ch(valid_ch, en);
      end
      prev_valid = valid;
    end
  end

  task automatic check_all_results(input string req);
    for (int c = 0; c < 4; c++) chk(req, int'(result[c]), int'(exp_res[c]));
  endtask

  task automatic stop_scan();
    @(negedge clk);
    mon_on = 0;
    run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_scan(input logic [3:0] e, input logic [2:0] d);
    @(negedge clk);
    en = e; div = d;
    period = slot_cycles(d);
    have_last = 0; exp_ch = 2'd0;
    mon_on = 1;
    run = 1'b1;
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = pulses + n;
    while (pulses < target) @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd839);
    for (int c = 0; c < 4; c++) begin vin[c] = '0; exp_res[c] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 result", int'(result), 0);
    chk("R10 trial", int'(trial), 0);
    chk("R10 mux", int'(mux_sel), 0);
    chk("R10 valid", int'(valid), 0);
    chk("R10 bytes", int'({rd_msb, rd_lsb}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners: full-scale and zero on the fastest clock, R6
    vin[0] = 10'd1023; vin[1] = 10'd0; vin[2] = 10'd512; vin[3] = 10'd511;
    start_scan(4'b1111, 3'd1);
    wait_pulses(8);
    stop_scan();
    check_all_results("R6 corners");

    // R8 byte presentation
    for (int c = 0; c < 4; c++) begin
      rd_ch = 2'(c);
      @(negedge clk);
      chk("R8 msb", int'(rd_msb), int'(exp_res[c] >> 2));
      chk("R8 lsb", int'(rd_lsb), int'(exp_res[c] & 10'd3));
    end

    // R4: stopped scan holds results despite new inputs
    for (int c = 0; c < 4; c++) vin[c] = 10'($urandom);
    begin
      int p0;
      p0 = pulses;
      repeat (500) @(negedge clk);
      chk("R4 no strobe while stopped", pulses - p0, 0);
    end
    check_all_results("R4 frozen");

    // R5: master channel disabled blocks all conversions
    begin
      int p0;
      @(negedge clk); en = 4'b1110; div = 3'd1; run = 1'b1;
      p0 = pulses;
      repeat (600) @(negedge clk);
      chk("R5 no strobe without ch0", pulses - p0, 0);
      check_all_results("R5 results held");
      run = 1'b0;
    end

    // R1: powersave code stops conversions
    begin
      int p0;
      @(negedge clk); en = 4'b1111; div = 3'd0; run = 1'b1;
      p0 = pulses;
      repeat (600) @(negedge clk);
      chk("R1 powersave no strobe", pulses - p0, 0);
      check_all_results("R1 results held");
      run = 1'b0;
    end

    // R7: after restart, channel 2 keeps old value until its own conversion
    begin
      logic [9:0] old2;
      repeat (3) @(negedge clk);
      old2 = exp_res[2];
      vin[2] = ~old2;
      start_scan(4'b0101, 3'd2);
      wait_pulses(1);
      @(negedge clk);
      chk("R7 previous result kept", int'(result[2]), int'(old2));
      wait_pulses(2);
      stop_scan();
      chk("R7 updated", int'(result[2]), int'(vin[2]));
    end

    // R1 slowest divider: spacing measured by monitor, single channel
    vin[0] = 10'($urandom);
    start_scan(4'b0001, 3'd7);
    wait_pulses(3);
    stop_scan();

    // constrained random runs, R1 R2 R3 R6
    for (int it = 0; it < 12; it++) begin
      logic [3:0] e;
      logic [2:0] d;
      e = 4'($urandom) | 4'b0001;
      d = 3'($urandom_range(1, 4));
      for (int c = 0; c < 4; c++) vin[c] = 10'($urandom);
      start_scan(e, d);
      wait_pulses(2 * $countones(e) + 1);
      stop_scan();
      check_all_results("R7 random hold");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule